// File: doc/BRIEF.md
# Synchronous Register Access Port with Dual Bus Handshake

This block lets a host processor read and write a small bank of byte-wide registers through an 8-bit data path and a 3-bit address. Every pin is sampled on the system clock. A static mode pin selects one of two bus styles on the same pins. In style 0 the host drives separate active-low read and write strobes, and the block answers with an active-low "not ready" level that it releases when the access is served. In style 1 the host drives one active-low data strobe and a read/write direction line, and the block answers with an active-low acknowledge.

The handshake latency is fixed in clock edges, counted from the first edge that sees chip select and a strobe active together. Reads of address 0 take one edge longer than reads of other addresses, because that address stands for a slower internal access. Writes take a fixed latency that depends on the style. An access ends only when the host raises chip select and an edge samples it high. The host can hold the strobes between accesses and toggle only chip select to run back-to-back transfers. Read data goes to a data output and an output-enable signal, which drive an external pad tristate.

Top module: `ctl_port_sync`

## Requirements
- R1: `mode_i`=0 selects strobe style (`rd_n` low = read, `wr_n` low = write, write wins if both low); `mode_i`=1 selects direction style (`rd_n` is the data strobe, `wr_n`=1 read, `wr_n`=0 write). Chip select `cs_n` is active low in both.
- R2: In style 0, `rdy_o` is low in the same cycle, without a clock edge, whenever `cs_n` and a strobe are low and the access has not yet been served.
- R3: In style 0, a read served at edge N (first edge with the request) raises `rdy_o` right after edge N+3 for address 0 and right after edge N+2 for any other address.
- R4: In style 0, a write raises `rdy_o` right after edge N+2 for every address.
- R5: In style 1, `rdy_o` (acknowledge) goes low right after edge N+3 for a read of address 0, after N+2 for reads of other addresses, and after N+3 for every write. It stays high before that.
- R6: An access finishes only at an edge that samples `cs_n` high. In style 1, `rdy_o` is high after that edge. If `cs_n` rises before the acknowledge, the access is dropped and no acknowledge appears.
- R7: `rdata_oe_o` is high only while `cs_n` is low and a read is requested. While it is high, `rdata_o` shows the register at `addr_i`. Otherwise `rdata_o` is zero.
- R8: A write stores `wdata_i` into the register at `addr_i` at edge N only. Changing `wdata_i` later in the same access leaves the stored value unchanged.
- R9: With the strobes held active, a new access starts at the first edge after completion that sees `cs_n` low again, and its latency counts from that edge.
- R10: After reset, all registers read zero, `rdata_oe_o` is low, and `rdy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Bus style select (0 strobes, 1 direction line) |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Style 0 read strobe / style 1 data strobe, active low |
| wr_n | input | 1 | Style 0 write strobe / style 1 direction (1 read, 0 write) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data from host |
| rdata_o | output | 8 | Read data toward pad |
| rdata_oe_o | output | 1 | Pad drive enable for read data |
| rdy_o | output | 1 | Style 0 ready / style 1 acknowledge, active low |

## Verification
Each address is written and read in both styles, with back-to-back accesses where only chip select toggles. The handshake level is sampled at every edge from N to past the expected release. This separates the fast read timing from the slow address-0 timing, and the style-0 write timing from the style-1 write timing. The data written in one style is read back in the other, with different data in each pass, so that a wrong address decode or a missing write shows up. The data input is changed after capture to show that only edge N stores data. One style-1 read is dropped early by raising chip select, to show that no acknowledge follows.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;

  localparam int LAT_W    = 2;
  localparam int LAT_FAST = 2;
  localparam int LAT_SLOW = 3;

  // Edges from the request edge to the release edge.
  function automatic logic [LAT_W-1:0] hs_latency(input logic style,
                                                  input logic is_wr,
                                                  input logic slow_addr);
    logic [LAT_W-1:0] lat;
    if (is_wr) begin
      lat = style ? LAT_W'(LAT_SLOW) : LAT_W'(LAT_FAST);
    end else begin
      lat = slow_addr ? LAT_W'(LAT_SLOW) : LAT_W'(LAT_FAST);
    end
    return lat;
  endfunction

endpackage

// File: rtl/cpp_decode.sv
module cpp_decode (
  input  logic style_i,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_req_o,
  output logic wr_req_o
);

  logic sel;
  assign sel = ~cs_n;

  always_comb begin
    if (style_i) begin
      rd_req_o = sel & ~rd_n & wr_n;
      wr_req_o = sel & ~rd_n & ~wr_n;
    end else begin
      wr_req_o = sel & ~wr_n;
      rd_req_o = sel & ~rd_n & wr_n;
    end
  end

  always_comb begin
    assert_excl_req_R1: assert (!(rd_req_o && wr_req_o));
  end

endmodule

// File: rtl/cpp_hshake.sv
module cpp_hshake
  import ctl_port_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int SLOW_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              style_i,
  input  logic              cs_n,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_cap_o,
  output logic              served_o,
  output logic              busy_o
);

  hs_state_e        state_q, state_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             req;
  logic             slow;

  assign req  = rd_req_i | wr_req_i;
  assign slow = (addr_i == ADDR_W'(SLOW_ADDR));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lat_d   = lat_q;
    unique case (state_q)
      HS_IDLE: begin
        if (req) begin
          state_d = HS_WAIT;
          cnt_d   = LAT_W'(1);
          lat_d   = hs_latency(style_i, wr_req_i, slow);
        end
      end
      HS_WAIT: begin
        if (cs_n) begin
          state_d = HS_IDLE;
        end else if (cnt_q == lat_q) begin
          state_d = HS_DONE;
        end else begin
          cnt_d = cnt_q + LAT_W'(1);
        end
      end
      HS_DONE: begin
        if (cs_n) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lat_q   <= lat_d;
    end
  end

  assign wr_cap_o = (state_q == HS_IDLE) & wr_req_i;
  assign served_o = (state_q == HS_DONE);
  assign busy_o   = (state_q == HS_WAIT);

  assert_min_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(served_o) |-> $past(busy_o, 2));

  assert_done_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (served_o && !cs_n) |=> served_o);

endmodule

// File: rtl/cpp_regfile.sv
module cpp_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i & (addr_i == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (hit) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = regs_q[addr_i];

  assert_single_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> !wr_en_i);

endmodule

// File: rtl/ctl_port_sync.sv
module ctl_port_sync #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int SLOW_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              rdy_o
);

  logic              rd_req, wr_req;
  logic              wr_cap, served, busy;
  logic [DATA_W-1:0] reg_val;

  cpp_decode u_dec (
    .style_i  (mode_i),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .rd_req_o (rd_req),
    .wr_req_o (wr_req)
  );

  cpp_hshake #(.ADDR_W(ADDR_W), .SLOW_ADDR(SLOW_ADDR)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .style_i  (mode_i),
    .cs_n     (cs_n),
    .rd_req_i (rd_req),
    .wr_req_i (wr_req),
    .addr_i   (addr_i),
    .wr_cap_o (wr_cap),
    .served_o (served),
    .busy_o   (busy)
  );

  cpp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_cap),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (reg_val)
  );

  assign rdata_oe_o = rd_req;
  assign rdata_o    = rd_req ? reg_val : '0;

  // Style 0: not-ready while a request is pending; style 1: acknowledge once served.
  always_comb begin
    if (mode_i) rdy_o = ~served;
    else        rdy_o = ~((rd_req | wr_req) & ~served);
  end

  assert_oe_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe_o |-> !cs_n);

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && cs_n) |=> (rdy_o || !mode_i));

  assert_no_ack_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && busy) |-> rdy_o);

  assert_ready_when_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && served) |-> rdy_o);

endmodule

// File: tb/tb_ctl_port_sync.sv
module tb_ctl_port_sync;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_i, cs_n, rd_n, wr_n;
  logic [2:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic       rdata_oe_o, rdy_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [8];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ctl_port_sync dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .rdy_o(rdy_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One access; strobes stay asserted afterwards (R9 back-to-back style).
  task automatic access(input logic m, input logic w, input logic [2:0] a,
                        input logic [7:0] d);
    int lat;
    logic exp_r;
    @(negedge clk);
    mode_i = m; addr_i = a; wdata_i = d; cs_n = 1'b0;
    if (m) begin rd_n = 1'b0; wr_n = ~w; end   // R1 style 1 pins
    else   begin rd_n = w;    wr_n = ~w; end   // R1 style 0 pins
    #1;
    if (m) check("R5 ack idle", {7'd0, rdy_o}, 8'd1);
    else   check("R2 ready low", {7'd0, rdy_o}, 8'd0);
    check("R7 oe", {7'd0, rdata_oe_o}, {7'd0, ~w});
    if (!w) check("R7 rdata", rdata_o, model[a]);
    if (w)  lat = m ? 3 : 2;
    else    lat = (a == 3'd0) ? 3 : 2;
    for (int j = 0; j <= lat + 1; j++) begin
      @(posedge clk); #1;
      exp_r = m ? (j < lat) : (j >= lat);
      if (m)      check("R5 ack timing", {7'd0, rdy_o}, {7'd0, exp_r});
      else if (w) check("R4 write ready", {7'd0, rdy_o}, {7'd0, exp_r});
      else        check("R3 read ready", {7'd0, rdy_o}, {7'd0, exp_r});
      if (j == 0) wdata_i = ~d;   // R8: later data must not be stored
    end
    if (w) model[a] = d;
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    check("R7 oe off", {7'd0, rdata_oe_o}, 8'd0);
    check("R7 rdata zero", rdata_o, 8'd0);
    @(posedge clk); #1;
    check("R6 release", {7'd0, rdy_o}, 8'd1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'd0;
    rst_n = 1'b0; mode_i = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr_i = '0; wdata_i = '0;
    #12;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R10 rdy", {7'd0, rdy_o}, 8'd1);
    check("R10 oe", {7'd0, rdata_oe_o}, 8'd0);
    // R10: registers read zero after reset
    access(1'b0, 1'b0, 3'd5, 8'd0);
    access(1'b1, 1'b0, 3'd0, 8'd0);
    // Sweep: write in one style, read back in the other (R3 R4 R5 R8 R9)
    for (int a = 0; a < 8; a++) access(1'b0, 1'b1, 3'(a), 8'(8'h10 + a * 8'h11));
    for (int a = 0; a < 8; a++) access(1'b1, 1'b0, 3'(a), 8'd0);
    for (int a = 0; a < 8; a++) access(1'b1, 1'b1, 3'(a), 8'(8'hA5 ^ (a * 8'h1B)));
    for (int a = 0; a < 8; a++) access(1'b0, 1'b0, 3'(a), 8'd0);
    // R6: style 1 read dropped before acknowledge
    @(negedge clk);
    mode_i = 1'b1; addr_i = 3'd3; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(posedge clk); #1;
      check("R6 dropped no ack", {7'd0, rdy_o}, 8'd1);
    end
    // R1: style 0 with both strobes low acts as a write
    @(negedge clk);
    mode_i = 1'b0; addr_i = 3'd6; wdata_i = 8'h3C; cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    #1;
    check("R1 write wins oe", {7'd0, rdata_oe_o}, 8'd0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    model[6] = 8'h3C;
    repeat (4) @(negedge clk);
    access(1'b1, 1'b0, 3'd6, 8'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule